// File: doc/BRIEF.md
# On-Chip SRAM Window Decoder

This block sits between a processor's access path and a small on-chip SRAM. It holds one programmable window register. The register carries the SRAM's base address, an enable bit, a bit that binds the SRAM to either instruction fetches or data references, a write-protect bit and five inhibit bits, one for each address space. For every request, the block decides in the same cycle whether the access belongs to the SRAM. If it does, the block drives the SRAM read or write enable. If it does not, the block flags a miss so that the access can be sent to the external bus instead.

A write that falls inside the window while write protection is on does not fall through as a miss. It raises a write-protect access error and leaves the array untouched. A request that is inhibited by its address-space bit, that targets the wrong port, or that lies outside the window is simply a miss.

For testing, the SRAM itself is modelled as a synchronous word array. A read that hits returns its word one clock later on a response valid/data pair. The request side has no ready signal: the decoder accepts a request in every cycle that `req_valid` is high, and it never applies back-pressure. The response side has no ready signal either, so the consumer must take `rsp_data` in the cycle that `rsp_valid` is high. The SRAM contents are undefined after reset. Software must load the window register with the enable bit set before it uses the array.

Top module: `sram_window_decoder`

## Requirements
- R1: After reset the window register reads as all zeros, and no request can produce `hit` or `wp_err`.
- R2: Register bit 0 is the enable bit. While it is 0, every valid request is a miss.
- R3: Register bit 7 selects the port. When it is 1, only requests with `req_ifetch`=1 can hit. When it is 0, only requests with `req_ifetch`=0 can hit.
- R4: Register bits 5..1 inhibit the address spaces. Bit 5 inhibits `req_space`=0 (CPU space / interrupt acknowledge), bit 4 inhibits 1 (supervisor code), bit 3 inhibits 2 (supervisor data), bit 2 inhibits 3 (user code) and bit 1 inhibits 4 (user data). A set bit turns the request into a miss with no error. Codes 5..7 are always misses.
- R5: A request can hit only if `req_addr[31:10]` equals register bits 31..10. The window is 1 KB at the default parameters.
- R6: A read hit asserts `mem_rd_en`. One cycle later, `rsp_valid` is 1 and `rsp_data` holds the word last stored at that index. `rsp_valid` is 0 in every other cycle.
- R7: A write hit with register bit 8 at 0 asserts `mem_wr_en` and stores `req_wdata`. With bit 8 at 1, the same write asserts `wp_err` instead of `hit`, and the stored word is unchanged.
- R8: Register bits 6 and 9 are reserved. They read as 0 and ignore written values. All other bits read back as written.
- R9: At most one of `hit`, `wp_err` and `miss` is 1. Exactly one of them is 1 when `req_valid` is 1, and all three are 0 when `req_valid` is 0.
- R10: A register write takes effect at the next rising clock edge. `mem_index` equals `req_addr[9:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Window register write strobe |
| cfg_wdata | input | 32 | Window register write value |
| cfg_rdata | output | 32 | Window register read-back |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Request byte address |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data reference |
| req_space | input | 3 | Address-space code (0..4, see R4) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| hit | output | 1 | Request is served by the SRAM |
| wp_err | output | 1 | Write-protect access error |
| miss | output | 1 | Request goes to the external bus |
| mem_rd_en | output | 1 | SRAM read enable |
| mem_wr_en | output | 1 | SRAM write enable |
| mem_index | output | 8 | SRAM word index |
| rsp_valid | output | 1 | Read data valid (one cycle after a read hit) |
| rsp_data | output | 32 | Read data |

## Verification
The assertions take the request inputs to be stable across each rising edge, because `mem_rd_en` and the response relation are sampled there. They also take `req_write` to be a real direction whenever `req_valid` is high. The bench changes every input only on the falling edge, so the decoder sees settled values at each rising edge. The sweep drives every space code, including the undefined codes 5..7, against all 256 combinations of enable, port, protect and inhibit bits. Reserved bits are always set in the written value, so the masking of those bits is exercised on every register load.

// File: rtl/sram_win_pkg.sv
package sram_win_pkg;

  // Address-space codes presented on req_space
  typedef enum logic [2:0] {
    SPC_CPU   = 3'd0,
    SPC_SCODE = 3'd1,
    SPC_SDATA = 3'd2,
    SPC_UCODE = 3'd3,
    SPC_UDATA = 3'd4
  } space_e;

  // Fixed field positions decoded by the match logic
  localparam int EN_BIT    = 0;
  localparam int INH_LO    = 1;
  localparam int INH_HI    = 5;
  localparam int PORT_BIT  = 7;
  localparam int WPROT_BIT = 8;
  localparam int NUM_SPC   = INH_HI - INH_LO + 1;

  typedef struct packed {
    logic               enable;
    logic               ifetch_port;
    logic               wprot;
    logic [NUM_SPC-1:0] inhibit;   // [4] = CPU space ... [0] = user data
  } win_ctl_t;

  function automatic logic bit_writable(input int b, input int base_lsb);
    return (b >= base_lsb) || (b == WPROT_BIT) || (b == PORT_BIT) ||
           ((b >= INH_LO) && (b <= INH_HI)) || (b == EN_BIT);
  endfunction

  function automatic logic [63:0] writable_mask(input int width, input int base_lsb);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < width; b++) m[b] = bit_writable(b, base_lsb);
    return m;
  endfunction

  // Space code 0 maps to the highest inhibit bit; undefined codes are blocked.
  function automatic logic space_blocked(input logic [NUM_SPC-1:0] inh,
                                         input logic [2:0] spc);
    if (int'(spc) >= NUM_SPC) return 1'b1;
    return inh[NUM_SPC-1-int'(spc)];
  endfunction

endpackage

// File: rtl/sram_win_basereg.sv
module sram_win_basereg
  import sram_win_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          wdata,
  output logic [ADDR_W-1:0]          rdata,
  output win_ctl_t                   ctl,
  output logic [ADDR_W-BASE_LSB-1:0] base
);

  localparam logic [63:0]       WMASK64 = writable_mask(ADDR_W, BASE_LSB);
  localparam logic [ADDR_W-1:0] WMASK   = WMASK64[ADDR_W-1:0];

  logic [ADDR_W-1:0] reg_q;

  // One flop per implemented bit; reserved positions are constant zero.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (WMASK[b]) begin : g_rw
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (we) q <= wdata[b];
      end
      assign reg_q[b] = q;
    end else begin : g_rsv
      assign reg_q[b] = 1'b0;
    end
  end

  logic unused_rsv_wdata;
  assign unused_rsv_wdata = ^(wdata & ~WMASK);

  assign rdata           = reg_q;
  assign base            = reg_q[ADDR_W-1:BASE_LSB];
  assign ctl.enable      = reg_q[EN_BIT];
  assign ctl.ifetch_port = reg_q[PORT_BIT];
  assign ctl.wprot       = reg_q[WPROT_BIT];
  assign ctl.inhibit     = reg_q[INH_HI:INH_LO];

endmodule

// File: rtl/sram_win_match.sv
module sram_win_match
  import sram_win_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_ifetch,
  input  logic [2:0]       req_space,
  input  logic             req_write,
  input  win_ctl_t         ctl,
  input  logic [TAG_W-1:0] base,
  output logic             hit,
  output logic             wp_err,
  output logic             miss,
  output logic             rd_en,
  output logic             wr_en
);

  logic in_window, port_ok, blocked, claim, protect_hit;

  always_comb begin
    in_window   = (req_tag == base);
    port_ok     = (ctl.ifetch_port == req_ifetch);
    blocked     = space_blocked(ctl.inhibit, req_space);
    claim       = req_valid && ctl.enable && port_ok && in_window && !blocked;
    protect_hit = req_write && ctl.wprot;
    hit         = claim && !protect_hit;
    wp_err      = claim && protect_hit;
    miss        = req_valid && !claim;
    rd_en       = hit && !req_write;
    wr_en       = hit && req_write;
  end

endmodule

// File: rtl/sram_win_array.sv
module sram_win_array #(
  parameter int WORDS  = 256,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata <= mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_en;
  end

endmodule

// File: rtl/sram_window_decoder.sv
module sram_window_decoder
  import sram_win_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 1024,
  localparam int BASE_LSB = $clog2(MEM_BYTES),
  localparam int BYTE_LSB = $clog2(DATA_W / 8),
  localparam int WORDS    = MEM_BYTES / (DATA_W / 8),
  localparam int IDX_W    = BASE_LSB - BYTE_LSB,
  localparam int TAG_W    = ADDR_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ifetch,
  input  logic [2:0]        req_space,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              hit,
  output logic              wp_err,
  output logic              miss,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [IDX_W-1:0]  mem_index,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  win_ctl_t         ctl;
  logic [TAG_W-1:0] base;

  sram_win_basereg #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .ctl   (ctl),
    .base  (base)
  );

  logic unused_byte_lane;
  assign unused_byte_lane = ^req_addr[BYTE_LSB-1:0];
  assign mem_index        = req_addr[BASE_LSB-1:BYTE_LSB];

  sram_win_match #(.TAG_W(TAG_W)) u_match (
    .req_valid  (req_valid),
    .req_tag    (req_addr[ADDR_W-1:BASE_LSB]),
    .req_ifetch (req_ifetch),
    .req_space  (req_space),
    .req_write  (req_write),
    .ctl        (ctl),
    .base       (base),
    .hit        (hit),
    .wp_err     (wp_err),
    .miss       (miss),
    .rd_en      (mem_rd_en),
    .wr_en      (mem_wr_en)
  );

  sram_win_array #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (mem_rd_en),
    .wr_en  (mem_wr_en),
    .idx    (mem_index),
    .wdata  (req_wdata),
    .rvalid (rsp_valid),
    .rdata  (rsp_data)
  );

endmodule

// File: rtl/sram_win_checker.sv
module sram_win_checker
  import sram_win_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_rdata,
  input logic              req_valid,
  input logic              req_ifetch,
  input logic              req_write,
  input logic              hit,
  input logic              wp_err,
  input logic              miss,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              rsp_valid
);

  localparam logic [63:0]       WM64  = writable_mask(ADDR_W, BASE_LSB);
  localparam logic [ADDR_W-1:0] WMASK = WM64[ADDR_W-1:0];

  AST_DISABLED_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[EN_BIT] |-> (!hit && !wp_err)); // R2
  AST_PORT_BINDING: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || wp_err) |-> (cfg_rdata[PORT_BIT] == req_ifetch)); // R3
  AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> rsp_valid); // R6
  AST_NO_STRAY_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rd_en)); // R6
  AST_PROTECTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wp_err |-> (cfg_rdata[WPROT_BIT] && req_write && !mem_wr_en)); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~WMASK) == '0); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit, wp_err, miss}) == (req_valid ? 1 : 0)); // R9
  AST_ENABLES_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> (hit && $onehot0({mem_rd_en, mem_wr_en}))); // R9

endmodule

bind sram_window_decoder sram_win_checker #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rdata  (cfg_rdata),
  .req_valid  (req_valid),
  .req_ifetch (req_ifetch),
  .req_write  (req_write),
  .hit        (hit),
  .wp_err     (wp_err),
  .miss       (miss),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .rsp_valid  (rsp_valid)
);

// File: tb/sram_window_decoder_test.sv
`timescale 1ns/1ps
module sram_window_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ifetch = 1'b0;
  logic [2:0]  req_space = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        hit, wp_err, miss, mem_rd_en, mem_wr_en, rsp_valid;
  logic [7:0]  mem_index;
  logic [31:0] rsp_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  sram_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_ifetch(req_ifetch), .req_space(req_space), .req_write(req_write),
    .req_wdata(req_wdata), .hit(hit), .wp_err(wp_err), .miss(miss),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_index(mem_index),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  localparam logic [31:0] RW_BITS = 32'hFFFF_FDBF;  // R8: bits 6 and 9 reserved
  localparam logic [31:0] MEM_WIN = 32'h2000_0400;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pattern(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {b, ~b, b ^ 8'h5A, 8'hC3};
  endfunction

  task automatic load_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_req(input logic v, input logic [31:0] a, input logic f,
                         input logic [2:0] s, input logic w, input logic [31:0] d);
    req_valid = v; req_addr = a; req_ifetch = f; req_space = s;
    req_write = w; req_wdata = d;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] cfgv, addr;
    logic en, port, wp, blk, inr, claim, e_hit, e_err;

    // R1: reset state
    put_req(1'b1, 32'h0, 1'b0, 3'd2, 1'b0, '0);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reg during reset", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reg after reset", cfg_rdata, 32'h0);
    chk("R1 outcome {hit,err,miss}", {29'd0, hit, wp_err, miss}, 32'd1);

    // R9: idle request
    @(negedge clk);
    put_req(1'b0, MEM_WIN, 1'b0, 3'd2, 1'b0, '0);
    #1;
    chk("R9 idle outputs", {27'd0, hit, wp_err, miss, mem_rd_en, mem_wr_en}, 32'd0);

    // R10: register write timing
    @(negedge clk);
    put_req(1'b1, MEM_WIN + 32'h0000_01F4, 1'b0, 3'd2, 1'b0, '0);
    cfg_we = 1'b1; cfg_wdata = MEM_WIN | 32'h1;
    #1;
    chk("R10 old value before edge", {31'd0, hit}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R10 new value after edge", {31'd0, hit}, 32'd1);
    chk("R10 word index", {24'd0, mem_index}, 32'd125);

    // Sweep of control bits against every request kind
    for (int c = 0; c < 256; c++) begin
      en   = c[0]; port = c[1]; wp = c[2];
      cfgv = 32'hABCD_E400 | (32'(wp) << 8) | (32'(port) << 7) |
             (32'(c[7:3]) << 1) | 32'(en) | 32'h0000_0240;
      load_cfg(cfgv);
      #1;
      chk("R8 reserved readback", cfg_rdata, cfgv & RW_BITS);
      for (int s = 0; s < 8; s++) begin
        for (int k = 0; k < 8; k++) begin
          inr = k[0];
          addr = inr ? (32'hABCD_E400 + 32'(((s * 37 + k * 5) & 255) * 4))
                     : (32'hABCD_E400 ^ (k[1] ? 32'h8000_0000 : 32'h0000_0400));
          @(negedge clk);
          put_req(1'b1, addr, k[2], 3'(s), k[1], 32'h1234_0000 + 32'(k));
          #1;
          blk   = (s > 4) ? 1'b1 : cfgv[5 - s];
          claim = en && (port == k[2]) && inr && !blk;
          e_err = claim && k[1] && wp;
          e_hit = claim && !(k[1] && wp);
          chk("R2/R3/R4/R5/R7/R9 outcome {hit,err,miss,rd,wr}",
              {27'd0, hit, wp_err, miss, mem_rd_en, mem_wr_en},
              {27'd0, e_hit, e_err, !claim, e_hit && !k[1], e_hit && k[1]});
        end
      end
      @(negedge clk);
      put_req(1'b0, '0, 1'b0, 3'd0, 1'b0, '0);
    end

    // R7: fill the array through write hits
    load_cfg(MEM_WIN | 32'h1);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      put_req(1'b1, MEM_WIN + 32'(i * 4), 1'b0, 3'd4, 1'b1, pattern(i));
    end
    @(negedge clk);
    put_req(1'b0, '0, 1'b0, 3'd0, 1'b0, '0);

    // R6: read back each word one cycle after the request
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      put_req(1'b1, MEM_WIN + 32'((255 - i) * 4), 1'b0, 3'd2, 1'b0, '0);
      @(negedge clk);
      put_req(1'b0, '0, 1'b0, 3'd0, 1'b0, '0);
      #1;
      chk("R6 rsp_valid", {31'd0, rsp_valid}, 32'd1);
      chk("R6 rsp_data", rsp_data, pattern(255 - i));
    end
    @(negedge clk); #1;
    chk("R6 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);

    // R7: protected write leaves the word untouched
    load_cfg(MEM_WIN | 32'h101);
    @(negedge clk);
    put_req(1'b1, MEM_WIN + 32'd20, 1'b0, 3'd2, 1'b1, 32'hDEAD_BEEF);
    #1;
    chk("R7 protected write {hit,err,wr}", {29'd0, hit, wp_err, mem_wr_en}, 32'd2);
    @(negedge clk);
    put_req(1'b0, '0, 1'b0, 3'd0, 1'b0, '0);
    load_cfg(MEM_WIN | 32'h1);
    @(negedge clk);
    put_req(1'b1, MEM_WIN + 32'd20, 1'b0, 3'd2, 1'b0, '0);
    @(negedge clk);
    put_req(1'b0, '0, 1'b0, 3'd0, 1'b0, '0);
    #1;
    chk("R7 word unchanged after protected write", rsp_data, pattern(5));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule